// File: doc/BRIEF.md
# Hamming Sector Code Comparator

This block decides what happened to one 512-byte sector protected by a 24-bit Hamming code. It takes the 3-byte code stored with the sector and the 3-byte code just computed from the sector data. Each code is rearranged into a 32-bit word, and the two words are XORed into a syndrome. The population count of the syndrome and the two words together select one of four results. The sector is clean, one data bit is wrong at a known byte and bit, the stored code field is itself damaged, or the damage cannot be corrected. A freshly erased sector reads back as all-ones stored and all-zero computed, and the block reports it as clean.

A start strobe loads both codes. The block registers its verdict and raises done for exactly one cycle on the clock after start. The verdict then holds until the next start. The input side has no ready signal and never applies back-pressure: a start is accepted in every cycle, back-to-back starts included, and each one overwrites the previous verdict one clock later. The block does not compute the code over the data and does not touch the sector buffer. The caller flips the reported bit.

Top module: `hamming_sector_check`

## Requirements
- R1: After reset, done is 0, status is 0 and both location outputs are 0. Done is 1 in exactly the cycle after each cycle in which start is 1, and 0 otherwise.
- R2: Each code carries byte0 on bits 7:0, byte1 on bits 15:8 and byte2 on bits 23:16. The repacked word places byte0 at 7:0, byte1 at 23:16, the low nibble of byte2 at 11:8 and the high nibble of byte2 at 31:28. Identical codes give status 0.
- R3: A syndrome with exactly 12 set bits gives status 1. err_bit is syndrome bits 18:16 and err_byte is syndrome bits 27:19.
- R4: A syndrome with exactly 1 set bit gives status 2, meaning the stored code field is damaged.
- R5: A stored code of 0xFFFFFF with a computed code of 0x000000 is an erased sector and gives status 0.
- R6: Any other nonzero syndrome gives status 3 (uncorrectable).
- R7: err_byte and err_bit are 0 whenever status is not 1.
- R8: While start is 0, changes on the code inputs have no effect: status and the location outputs keep the last verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Compare the present codes this cycle |
| stored_code | input | 24 | Code read back from the spare area |
| calc_code | input | 24 | Code computed over the sector data |
| done | output | 1 | One-cycle pulse, the verdict is valid |
| status | output | 2 | 0 clean, 1 corrected bit, 2 code field bad, 3 uncorrectable |
| err_byte | output | 9 | Byte index of the bad bit when status is 1 |
| err_bit | output | 3 | Bit index within that byte when status is 1 |

## Verification
The hardest case to reach is a single-bit verdict. The syndrome needs exactly twelve ones placed only on the bits that the repacking can reach, and the location field must come out at a known byte and bit. The stimulus builds such code pairs by hand from the byte mapping. It uses one pair with a zero computed code and one with both codes nonzero but the same XOR, so the verdict is shown to depend only on the syndrome. The erased-sector case is also checked against its near miss, all-ones stored with a single computed bit set, which must be reported as uncorrectable.

// File: rtl/hsc_pkg.sv
package hsc_pkg;
  localparam int CODE_W = 24;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    ST_CLEAN  = 2'd0,
    ST_FIXED  = 2'd1,
    ST_ECCBAD = 2'd2,
    ST_FATAL  = 2'd3
  } hsc_status_e;

  // Rearrange a 3-byte code into the 32-bit syndrome layout.
  function automatic logic [WORD_W-1:0] hsc_repack(input logic [CODE_W-1:0] code);
    logic [WORD_W-1:0] w;
    w        = '0;
    w[7:0]   = code[7:0];
    w[23:16] = code[15:8];
    w[11:8]  = code[19:16];
    w[31:28] = code[23:20];
    return w;
  endfunction
endpackage

// File: rtl/hsc_repack.sv
module hsc_repack
  import hsc_pkg::*;
(
  input  logic [CODE_W-1:0] code_in,
  output logic [WORD_W-1:0] word_out
);
  always_comb word_out = hsc_repack(code_in);
endmodule

// File: rtl/hsc_popcount.sv
module hsc_popcount #(
  parameter int W  = 32,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < W; i++) count = count + CW'(vec[i]);
  end
endmodule

// File: rtl/hsc_classify.sv
module hsc_classify
  import hsc_pkg::*;
#(
  parameter int W           = 32,
  parameter int CORR_WEIGHT = 12,
  parameter int BYTE_W      = 9,
  parameter int BIT_W       = 3,
  parameter logic [W-1:0] ERASED_WORD = '1,
  localparam int CW   = $clog2(W + 1),
  localparam int HALF = W / 2
) (
  input  logic [W-1:0]      stored_w,
  input  logic [W-1:0]      calc_w,
  input  logic [CW-1:0]     weight,
  output hsc_status_e       verdict,
  output logic [BYTE_W-1:0] loc_byte,
  output logic [BIT_W-1:0]  loc_bit
);
  logic [W-1:0] syn;
  always_comb syn = stored_w ^ calc_w;

  always_comb begin
    verdict  = ST_CLEAN;
    loc_byte = '0;
    loc_bit  = '0;
    if (syn != '0) begin
      if (weight == CW'(CORR_WEIGHT)) begin
        verdict  = ST_FIXED;
        loc_bit  = syn[HALF +: BIT_W];
        loc_byte = syn[HALF + BIT_W +: BYTE_W];
      end else if (weight == CW'(1)) begin
        verdict = ST_ECCBAD;
      end else if (stored_w == ERASED_WORD && calc_w == '0) begin
        verdict = ST_CLEAN;
      end else begin
        verdict = ST_FATAL;
      end
    end
  end
endmodule

// File: rtl/hamming_sector_check.sv
module hamming_sector_check
  import hsc_pkg::*;
#(
  parameter int CORR_WEIGHT = 12,
  parameter int BYTE_W      = 9,
  parameter int BIT_W       = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] stored_code,
  input  logic [CODE_W-1:0] calc_code,
  output logic              done,
  output logic [1:0]        status,
  output logic [BYTE_W-1:0] err_byte,
  output logic [BIT_W-1:0]  err_bit
);
  localparam int NCODE = 2;
  localparam int CW    = $clog2(WORD_W + 1);
  localparam logic [WORD_W-1:0] ERASED_WORD = hsc_repack({CODE_W{1'b1}});

  logic [CODE_W-1:0] codes [NCODE];
  logic [WORD_W-1:0] words [NCODE];
  logic [CW-1:0]     weight;
  hsc_status_e       verdict;
  logic [BYTE_W-1:0] loc_byte;
  logic [BIT_W-1:0]  loc_bit;

  always_comb begin
    codes[0] = stored_code;
    codes[1] = calc_code;
  end

  for (genvar g = 0; g < NCODE; g++) begin : g_pack
    hsc_repack u_pack (.code_in(codes[g]), .word_out(words[g]));
  end

  hsc_popcount #(.W(WORD_W)) u_pop (
    .vec  (words[0] ^ words[1]),
    .count(weight)
  );

  hsc_classify #(
    .W(WORD_W), .CORR_WEIGHT(CORR_WEIGHT), .BYTE_W(BYTE_W),
    .BIT_W(BIT_W), .ERASED_WORD(ERASED_WORD)
  ) u_cls (
    .stored_w(words[0]),
    .calc_w  (words[1]),
    .weight  (weight),
    .verdict (verdict),
    .loc_byte(loc_byte),
    .loc_bit (loc_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      status   <= ST_CLEAN;
      err_byte <= '0;
      err_bit  <= '0;
    end else begin
      done <= start;
      if (start) begin
        status   <= verdict;
        err_byte <= loc_byte;
        err_bit  <= loc_bit;
      end
    end
  end

  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done); // R1
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done); // R1
  AST_FIX_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && verdict == ST_FIXED) |-> weight == CW'(CORR_WEIGHT)); // R3
  AST_FIELD_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && verdict == ST_ECCBAD) |-> $countones(words[0] ^ words[1]) == 1); // R4
  AST_LOC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (status != 2'd1) |-> (err_byte == '0 && err_bit == '0)); // R7
  AST_HOLD_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(status) && $stable(err_byte) && $stable(err_bit))); // R8
endmodule

// File: tb/hamming_sector_check_bench.sv
`timescale 1ns/1ps
module hamming_sector_check_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] stored_code = '0;
  logic [23:0] calc_code = '0;
  logic        done;
  logic [1:0]  status;
  logic [8:0]  err_byte;
  logic [2:0]  err_bit;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  hamming_sector_check u_hamming_sector_check (
    .clk(clk), .rst_n(rst_n), .start(start),
    .stored_code(stored_code), .calc_code(calc_code),
    .done(done), .status(status), .err_byte(err_byte), .err_bit(err_bit)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // code = {byte2, byte1, byte0}
  task automatic run(input logic [23:0] s, input logic [23:0] c);
    @(negedge clk);
    stored_code = s;
    calc_code   = c;
    start       = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic expect_verdict(input string req, input int st, input int byt, input int bt);
    chk({req, " done"}, int'(done), 1);
    chk({req, " status"}, int'(status), st);
    chk({req, " byte"}, int'(err_byte), byt);
    chk({req, " bit"}, int'(err_bit), bt);
  endtask

  task automatic t_reset();
    chk("R1 reset done", int'(done), 0);
    chk("R1 reset status", int'(status), 0);
    chk("R7 reset byte", int'(err_byte), 0);
    chk("R7 reset bit", int'(err_bit), 0);
  endtask

  task automatic t_clean();
    run(24'h5A_3C_C3, 24'h5A_3C_C3);
    expect_verdict("R2 equal", 0, 0, 0);
    @(negedge clk);
    chk("R1 single pulse", int'(done), 0);
  endtask

  task automatic t_single();
    // syndrome 0x10A8_00FF: 12 ones, field 0x10A8 -> byte 21 bit 0
    run(24'h10_A8_FF, 24'h00_00_00);
    expect_verdict("R3 fix a", 1, 21, 0);
    // same syndrome from two nonzero codes
    run(24'h45_EC_CC, 24'h55_44_33);
    expect_verdict("R3 fix b", 1, 21, 0);
    // syndrome 0x9007_007F: byte 0 bit 7
    run(24'h90_07_7F, 24'h00_00_00);
    expect_verdict("R3 fix c", 1, 0, 7);
  endtask

  task automatic t_field();
    run(24'h01_00_00, 24'h00_00_00);
    expect_verdict("R4 field lo nibble", 2, 0, 0);
    run(24'h00_00_00, 24'h00_80_00);
    expect_verdict("R4 field byte1", 2, 0, 0);
  endtask

  task automatic t_erased();
    run(24'hFF_FF_FF, 24'h00_00_00);
    expect_verdict("R5 erased", 0, 0, 0);
  endtask

  task automatic t_fatal();
    run(24'h00_00_03, 24'h00_00_00);
    expect_verdict("R6 two bits", 3, 0, 0);
    run(24'hFF_FF_FF, 24'h00_00_01);
    expect_verdict("R6 near erased", 3, 0, 0);
  endtask

  task automatic t_hold();
    run(24'h90_07_7F, 24'h00_00_00);
    expect_verdict("R8 setup", 1, 0, 7);
    stored_code = 24'h00_00_03;
    calc_code   = 24'h12_34_56;
    repeat (3) @(negedge clk);
    chk("R8 hold done", int'(done), 0);
    chk("R8 hold status", int'(status), 1);
    chk("R8 hold bit", int'(err_bit), 7);
    // back-to-back starts: second verdict wins
    @(negedge clk);
    stored_code = 24'h10_A8_FF; calc_code = 24'h0; start = 1'b1;
    @(negedge clk);
    stored_code = 24'h01_00_00;
    @(negedge clk);
    start = 1'b0;
    expect_verdict("R1 back to back", 2, 0, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_single();
    t_field();
    t_erased();
    t_fatal();
    t_hold();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule